// File: doc/BRIEF.md
# ADC Serial Control-Byte Interface

This block is the device-side serial port of a 16-bit sampling converter whose analog core is replaced by a stub. A host drives an active-low select, a serial clock and a serial data line. The block samples the data line on each serial-clock rising edge, hunts for a start bit, and assembles an 8-bit control byte. Once the byte is complete, the block latches its mode fields and three general-purpose side outputs. It then starts a conversion and shifts a 16-bit result, taken from a parallel stub input, out most-significant bit first.

Every serial pin is sampled by a single fast system clock, and the serial-clock edges are detected from those samples. In external-clock mode a frame is 24 serial clocks long: 8 for the byte and 16 for the result. In internal-clock mode a stub converter runs for a set number of system clocks. During that time the strobe output is held low, and it signals completion by going high. An asynchronous active-low reset returns every piece of state to its defaults. An active-low shutdown input keeps the block from taking frames.

Top module: `adc_serial_if`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `pout` is 0, `unipolar`, `int_clk` and `acq_mode` are 0, `sstrb` is 0, and any frame in progress is dropped.
- R2: A frame starts at the first serial-clock rising edge that samples `din`=1 while `cs_n` is low, `shdn_n` is high and no frame is active. Zeros sampled before that edge have no effect.
- R3: While `cs_n` is high, `dout_oe` is 0, `dout` is 0, any active frame is abandoned, and serial-clock and data activity changes no output.
- R4: Control byte layout, with bit 7 first on the wire: bit 7 is the start bit; bit 6 is 1 for unipolar and 0 for bipolar; bit 5 is 1 for internal clock and 0 for external clock; bits 4:3 are the acquisition mode. The decoded fields appear on `unipolar`, `int_clk` and `acq_mode`.
- R5: `pout[2:0]` takes control bits 2:0, with all three bits changing together at the 8th rising edge of a frame. A frame cut short before that edge leaves `pout` and the mode outputs unchanged.
- R6: In external-clock mode, `sstrb` is high from the 8th rising edge to the 9th rising edge and low at all other times.
- R7: In external-clock mode, the result is captured from `result_i` at the 8th rising edge. `dout` is 0 until the next falling edge, then shows B15, and each later falling edge moves to the next bit, so B0 is on `dout` after the falling edge that follows the 23rd rising edge.
- R8: A frame ends at its 24th rising edge. After that `dout` is 0 and the block hunts for a new start bit without `cs_n` having to rise.
- R9: In internal-clock mode, `sstrb` goes low at the 8th rising edge, stays low for exactly `CONV_CYCLES` system clocks, then goes high. `result_i` is captured at that moment and B15 is driven at once. Each falling edge advances one bit, and the frame ends at the 16th rising edge after completion. Serial-clock edges during the conversion are ignored.
- R10: While `shdn_n` is low, any active frame is abandoned and no start bit is accepted. `pout` and the mode outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset to defaults |
| shdn_n | input | 1 | Active-low shutdown; blocks frames |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data, sampled on sclk rising edges |
| result_i | input | RES_W | Parallel result from the converter stub |
| dout | output | 1 | Serial result bit |
| dout_oe | output | 1 | Output enable for dout; 0 means high impedance |
| sstrb | output | 1 | Conversion strobe |
| pout | output | 3 | Latched side outputs from control bits 2:0 |
| unipolar | output | 1 | Latched input-range mode |
| int_clk | output | 1 | Latched clock-mode selection |
| acq_mode | output | 2 | Latched acquisition-mode field |

## Verification
The embedded assertions check, on every cycle, the properties that are local in time. Deselect or shutdown returns the framer to start-bit hunting. The latched fields change only on a byte-completing edge. The external strobe ends at the next rising edge. The result register moves only on a falling edge. The bit counter never passes the frame length. The stub only starts when idle. Whole-frame behaviour can only be shown by the bench scenarios: leading zeros, back-to-back frames, capture timing that differs between the clock modes, aborts through select, shutdown and reset, and the exact strobe-low length. For these the bench runs a behavioural model beside the design and compares every output on every clock.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

    localparam int CTRL_W  = 8;
    localparam int BIT_UNI = 6;
    localparam int BIT_INT = 5;
    localparam int BIT_M1  = 4;
    localparam int BIT_M0  = 3;
    localparam int POUT_W  = 3;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_CTRL,
        ST_EXT_WAIT,
        ST_SHIFT,
        ST_INT_WAIT
    } sif_state_e;

    typedef struct packed {
        logic              unipolar;
        logic              int_clk;
        logic [1:0]        acq;
        logic [POUT_W-1:0] pout;
    } mode_cfg_t;

    function automatic mode_cfg_t decode_ctrl(input logic [CTRL_W-1:0] b);
        mode_cfg_t c;
        c.unipolar = b[BIT_UNI];
        c.int_clk  = b[BIT_INT];
        c.acq      = {b[BIT_M1], b[BIT_M0]};
        c.pout     = b[POUT_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/sif_sclk_edge.sv
module sif_sclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic rise_o,
    output logic fall_o
);
    logic sclk_d, sclk_q;

    always_comb begin
        sclk_d = sclk_i;
        rise_o = sclk_i & ~sclk_q;
        fall_o = ~sclk_i & sclk_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_d;
    end

endmodule

// File: rtl/conv_stub.sv
module conv_stub #(
    parameter int CONV_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } stub_regs_t;

    stub_regs_t d, q;

    always_comb begin
        d      = q;
        done_o = q.busy && (q.cnt == '0);
        if (clr_i) begin
            d.busy = 1'b0;
            d.cnt  = '0;
        end else if (start_i) begin
            d.busy = 1'b1;
            d.cnt  = CW'(CONV_CYCLES - 1);
        end else if (done_o) begin
            d.busy = 1'b0;
        end else if (q.busy) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9: a conversion is only launched from idle
    a_r9_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !q.busy);
    // R9: completion ends the busy period
    a_r9_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !q.busy);

endmodule

// File: rtl/sif_frame.sv
module sif_frame
    import adc_sif_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort_i,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             din_i,
    input  logic [RES_W-1:0] result_i,
    input  logic             conv_done_i,
    output logic             conv_start_o,
    output logic             dout_o,
    output logic             sstrb_o,
    output mode_cfg_t        cfg_o
);
    localparam int FRAME_LEN = CTRL_W + RES_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);

    typedef struct packed {
        sif_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [CTRL_W-1:0] cbyte;
        logic [RES_W-1:0]  sh;
        logic              pulse;
        mode_cfg_t         cfg;
    } frame_regs_t;

    frame_regs_t d, q;
    logic [CTRL_W-1:0] byte_nxt;

    always_comb begin
        d            = q;
        conv_start_o = 1'b0;
        byte_nxt     = {q.cbyte[CTRL_W-2:0], din_i};
        if (abort_i) begin
            d.st    = ST_HUNT;
            d.cnt   = '0;
            d.pulse = 1'b0;
        end else begin
            if (rise_i) d.pulse = 1'b0;
            unique case (q.st)
                ST_HUNT: begin
                    if (rise_i && din_i) begin
                        d.st    = ST_CTRL;
                        d.cnt   = CNT_W'(1);
                        d.cbyte = CTRL_W'(1);
                    end
                end
                ST_CTRL: begin
                    if (rise_i) begin
                        d.cbyte = byte_nxt;
                        d.cnt   = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(CTRL_W - 1)) begin
                            d.cfg = decode_ctrl(byte_nxt);
                            if (byte_nxt[BIT_INT]) begin
                                d.st         = ST_INT_WAIT;
                                conv_start_o = 1'b1;
                            end else begin
                                d.st    = ST_EXT_WAIT;
                                d.pulse = 1'b1;
                                d.sh    = result_i;
                            end
                        end
                    end
                end
                ST_EXT_WAIT: begin
                    if (fall_i) d.st = ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (fall_i) d.sh = {q.sh[RES_W-2:0], 1'b0};
                    if (rise_i) begin
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(FRAME_LEN - 1)) begin
                            d.st  = ST_HUNT;
                            d.cnt = '0;
                        end
                    end
                end
                ST_INT_WAIT: begin
                    if (conv_done_i) begin
                        d.sh = result_i;
                        d.st = ST_SHIFT;
                    end
                end
                default: d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_HUNT;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        dout_o  = (q.st == ST_SHIFT) & q.sh[RES_W-1];
        sstrb_o = q.cfg.int_clk ? (q.st != ST_INT_WAIT) : q.pulse;
        cfg_o   = q.cfg;
    end

    // R3 / R10: deselect or shutdown sends the framer back to hunting
    a_r3_abort_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (q.st == ST_HUNT));
    // R5: latched fields move only on the byte-completing rising edge
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i || !(rise_i && q.st == ST_CTRL && q.cnt == CNT_W'(CTRL_W - 1)))
        |=> $stable(q.cfg));
    // R6: the external strobe ends at the following rising edge
    a_r6_pulse_one_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pulse && rise_i) |=> !q.pulse);
    // R7: the result register moves only on a falling edge while shifting
    a_r7_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && !fall_i) |=> $stable(q.sh));
    // R8: the rising-edge count never passes the frame length
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(FRAME_LEN));

endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
    import adc_sif_pkg::*;
#(
    parameter int RES_W       = 16,
    parameter int CONV_CYCLES = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shdn_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic [RES_W-1:0] result_i,
    output logic             dout,
    output logic             dout_oe,
    output logic             sstrb,
    output logic [2:0]       pout,
    output logic             unipolar,
    output logic             int_clk,
    output logic [1:0]       acq_mode
);
    logic      rise, fall, abort, conv_start, conv_done, frame_dout;
    mode_cfg_t cfg;

    assign abort = cs_n | ~shdn_n;

    sif_sclk_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk),
        .rise_o (rise),
        .fall_o (fall)
    );

    conv_stub #(.CONV_CYCLES(CONV_CYCLES)) u_stub (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (abort),
        .start_i (conv_start),
        .done_o  (conv_done)
    );

    sif_frame #(.RES_W(RES_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .abort_i      (abort),
        .rise_i       (rise),
        .fall_i       (fall),
        .din_i        (din),
        .result_i     (result_i),
        .conv_done_i  (conv_done),
        .conv_start_o (conv_start),
        .dout_o       (frame_dout),
        .sstrb_o      (sstrb),
        .cfg_o        (cfg)
    );

    always_comb begin
        dout_oe  = ~cs_n;
        dout     = ~cs_n & frame_dout;
        pout     = cfg.pout;
        unipolar = cfg.unipolar;
        int_clk  = cfg.int_clk;
        acq_mode = cfg.acq;
    end

endmodule

// File: tb/adc_serial_if_tb.sv
module adc_serial_if_tb;
    localparam int N_CONV = 40;

    logic clk = 1'b0;
    logic rst_n, shdn_n, cs_n, sclk, din;
    logic [15:0] result_i;
    logic dout, dout_oe, sstrb, unipolar, int_clk;
    logic [2:0] pout;
    logic [1:0] acq_mode;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    adc_serial_if #(.RES_W(16), .CONV_CYCLES(N_CONV)) u_dut (
        .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .cs_n(cs_n), .sclk(sclk),
        .din(din), .result_i(result_i), .dout(dout), .dout_oe(dout_oe),
        .sstrb(sstrb), .pout(pout), .unipolar(unipolar), .int_clk(int_clk),
        .acq_mode(acq_mode)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 byte, 2 await fall, 3 shifting, 4 converting
    int   ph, nr, tmr;
    logic m_sclk, m_pulse, m_dout, m_uni, m_int;
    logic [7:0] cb;
    logic [2:0] m_pout;
    logic [1:0] m_acq;
    bit   bq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0; nr = 0; tmr = 0; m_sclk = 0; m_pulse = 0; m_dout = 0;
            m_uni = 0; m_int = 0; m_acq = 0; m_pout = 0; cb = 0; bq.delete();
        end else begin
            bit rise, fall;
            rise = sclk && !m_sclk;
            fall = !sclk && m_sclk;
            m_sclk = sclk;
            if (cs_n || !shdn_n) begin
                ph = 0; m_pulse = 0;
            end else begin
                if (rise) m_pulse = 0;
                case (ph)
                    0: if (rise && din) begin ph = 1; nr = 1; cb = 8'd1; end
                    1: if (rise) begin
                        cb = {cb[6:0], din};
                        nr++;
                        if (nr == 8) begin
                            m_uni = cb[6]; m_int = cb[5]; m_acq = cb[4:3]; m_pout = cb[2:0];
                            if (cb[5]) begin ph = 4; tmr = N_CONV; end
                            else begin
                                ph = 2; m_pulse = 1; bq.delete();
                                for (int i = 15; i >= 0; i--) bq.push_back(result_i[i]);
                            end
                        end
                    end
                    2: if (fall) begin ph = 3; m_dout = bq.pop_front(); end
                    3: begin
                        if (fall) m_dout = (bq.size() > 0) ? bq.pop_front() : 1'b0;
                        if (rise) begin nr++; if (nr == 24) ph = 0; end
                    end
                    4: begin
                        tmr--;
                        if (tmr == 0) begin
                            bq.delete();
                            for (int i = 15; i >= 0; i--) bq.push_back(result_i[i]);
                            m_dout = bq.pop_front();
                            ph = 3;
                        end
                    end
                    default: ph = 0;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic e_dout, e_strb;
            e_dout = !cs_n && ph == 3 && m_dout;
            e_strb = m_int ? (ph != 4) : m_pulse;
            chk(dout === e_dout, "R7 dout", dout, e_dout);
            chk(dout_oe === !cs_n, "R3 dout_oe", dout_oe, !cs_n);
            chk(sstrb === e_strb, m_int ? "R9 sstrb" : "R6 sstrb", sstrb, e_strb);
            chk(pout === m_pout, "R5 pout", pout, m_pout);
            chk({unipolar, int_clk, acq_mode} === {m_uni, m_int, m_acq}, "R4 mode",
                {unipolar, int_clk, acq_mode}, {m_uni, m_int, m_acq});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL R8 watchdog actual=%0d expected=finish", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic sclk_cycle(input logic d, output logic q);
        @(negedge clk);
        din = d;
        repeat (3) @(negedge clk);
        q = dout;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] b, input bit internal,
                             input logic [15:0] later_res, output logic [15:0] rd);
        logic x;
        for (int i = 7; i >= 0; i--) sclk_cycle(b[i], x);
        result_i = later_res;
        if (internal) begin
            chk(sstrb === 1'b0, "R9 strobe low while converting", sstrb, 0);
            while (!sstrb) @(negedge clk);
        end else begin
            chk(sstrb === 1'b1, "R6 strobe after byte", sstrb, 1);
        end
        rd = '0;
        for (int i = 0; i < 16; i++) begin
            sclk_cycle(1'b0, x);
            rd = {rd[14:0], x};
        end
    endtask

    initial begin
        logic [15:0] rd;
        logic x;
        rst_n = 0; shdn_n = 1; cs_n = 1; sclk = 0; din = 0; result_i = '0;
        repeat (5) @(negedge clk);
        chk({pout, sstrb, int_clk, unipolar} === 6'b0, "R1 reset outputs", {pout, sstrb}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(dout_oe === 1'b0, "R3 deselected oe", dout_oe, 0);

        // R2: leading zeros, then an external frame
        cs_n = 0;
        repeat (3) sclk_cycle(1'b0, x);
        result_i = 16'hA5C3;
        run_frame(8'hCD, 0, 16'h0BAD, rd);
        chk(rd === 16'hA5C3, "R7 external capture at byte end", rd, 16'hA5C3);
        chk(pout === 3'd5, "R5 pout", pout, 5);
        chk(unipolar === 1'b1 && acq_mode === 2'b01, "R4 fields", {unipolar, acq_mode}, 3'b101);
        chk(dout === 1'b0, "R8 dout idle after frame", dout, 0);

        // R8: back-to-back frame without deselect
        result_i = 16'h1234;
        run_frame(8'h82, 0, 16'hFFFF, rd);
        chk(rd === 16'h1234, "R8 second frame data", rd, 16'h1234);
        chk(pout === 3'd2 && unipolar === 1'b0, "R4 second fields", {pout, unipolar}, 4'b0100);

        // R3 / R5: partial byte then deselect; activity while deselected
        repeat (4) sclk_cycle(1'b1, x);
        cs_n = 1;
        repeat (10) sclk_cycle(1'b1, x);
        chk(pout === 3'd2, "R3 partial byte ignored", pout, 2);
        chk(dout_oe === 1'b0 && dout === 1'b0, "R3 dout quiet", {dout_oe, dout}, 0);
        cs_n = 0;
        result_i = 16'h8001;
        run_frame(8'h87, 0, 16'h0000, rd);
        chk(rd === 16'h8001 && pout === 3'd7, "R2 fresh start after reselect", rd, 16'h8001);

        // R9: internal clock mode, result captured at completion
        result_i = 16'h5555;
        run_frame(8'hA3, 1, 16'h0F0F, rd);
        chk(rd === 16'h0F0F, "R9 internal capture at completion", rd, 16'h0F0F);
        chk(int_clk === 1'b1 && pout === 3'd3, "R4 internal fields", {int_clk, pout}, 4'b1011);
        chk(sstrb === 1'b1, "R9 strobe rests high", sstrb, 1);

        // R10: shutdown blocks a whole frame
        shdn_n = 0;
        run_frame(8'h86, 0, 16'h7777, rd);
        chk(pout === 3'd3 && int_clk === 1'b1, "R10 fields held in shutdown", pout, 3);
        chk(rd === 16'h0, "R10 no data in shutdown", rd, 0);
        shdn_n = 1;

        // R1: reset during a frame
        repeat (5) sclk_cycle(1'b1, x);
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk(pout === 3'd0 && int_clk === 1'b0 && sstrb === 1'b0, "R1 reset mid-frame",
            {pout, int_clk, sstrb}, 0);
        rst_n = 1;
        result_i = 16'hC3A5;
        run_frame(8'h81, 0, 16'h0, rd);
        chk(rd === 16'hC3A5 && pout === 3'd1, "R1 frame after reset", rd, 16'hC3A5);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule